// File: doc/BRIEF.md
# Burst Register Window

This block sits in front of a peripheral register file and gives a DMA engine one fixed data address through which it can sweep a run of consecutive registers. Software writes a control register holding a start word index and a burst length code. From then on, every read or write that lands on the window address is sent to the register at word (start + index). A hardware index counts these window accesses and wraps back to zero once the last register of the burst has been reached.

Every other address passes straight through to the register file, and the index does not move. The control register is served locally. The window carries 16-bit data. Both halfword and word accesses to it are accepted, and only the low half of the data path is forwarded. The register bus is single-cycle. Any cycle with a write or read strobe asserted is a completed access, and read data returns combinationally in that same cycle.

Top module: `burst_window`

## Requirements
- R1: After reset, the start field, the length field and the index are all zero: the control register reads 0 and the first window access targets byte address 0x00.
- R2: The control register is at byte offset 0x48. The start field is bits 4:0 and is written by byte lane 0. The length field is bits 12:8 and is written by byte lane 1. All other bits read zero.
- R3: A length value above 17 written to the control register is stored as 17. Values 0 to 17 are stored unchanged.
- R4: An access to byte offset 0x4C (the window) is forwarded with target byte address (start + index) * 4.
- R5: Each window access advances the index by one. The access made at index equal to the length field is followed by index 0, so a burst covers length+1 registers.
- R6: Any write to the control register clears the index to 0, whatever its byte enables.
- R7: An access to any address other than 0x48 or 0x4C is forwarded with unchanged address, strobes, byte enables and write data, returns the target read data unchanged, and does not move the index.
- R8: A window read returns bits 15:0 of the target read data, zero-extended, in the same cycle. A window write forwards wdata[15:0] with bits 31:16 zero and byte enables masked to bits 1:0.
- R9: Control register accesses are not forwarded: the downstream write and read strobes stay low.
- R10: Cycles with neither strobe asserted do not move the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Upstream byte address |
| bus_wr | input | 1 | Upstream write strobe |
| bus_rd | input | 1 | Upstream read strobe |
| bus_be | input | 4 | Upstream byte enables |
| bus_wdata | input | 32 | Upstream write data |
| bus_rdata | output | 32 | Upstream read data |
| reg_addr | output | 8 | Downstream byte address |
| reg_wr | output | 1 | Downstream write strobe |
| reg_rd | output | 1 | Downstream read strobe |
| reg_be | output | 4 | Downstream byte enables |
| reg_wdata | output | 32 | Downstream write data |
| reg_rdata | input | 32 | Downstream read data |

## Verification
The hardest situation to reach is a control write that lands in the middle of a burst. It has to reset the index while a partial sweep is under way, and it may carry byte enables that update only one of the two fields. Directed sequences first run complete and partial bursts at the extreme lengths 0 and 17, and check a clamped length of 31. Seeded random traffic then mixes window accesses with control writes that carry random byte enables, pass-through accesses and idle cycles. A bench model of start, length and index predicts every forwarded address.

// File: rtl/bw_pkg.sv
package bw_pkg;

   // Saturate a requested length code at the largest legal value.
   function automatic logic [4:0] clamp_len(input logic [4:0] req, input logic [4:0] lim);
      return (req > lim) ? lim : req;
   endfunction

endpackage

// File: rtl/bw_ctrl.sv
module bw_ctrl #(
   parameter int START_W = 5,
   parameter int LEN_W   = 5,
   parameter int MAX_LEN = 17,
   parameter int DATA_W  = 32,
   parameter int LEN_LSB = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [DATA_W/8-1:0] be,
   input  logic [DATA_W-1:0]  wdata,
   output logic [START_W-1:0] start,
   output logic [LEN_W-1:0]   len
);
   localparam logic [LEN_W-1:0] LIM = LEN_W'(MAX_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start <= '0;
         len   <= '0;
      end else if (wr) begin
         if (be[0]) start <= wdata[START_W-1:0];
         if (be[LEN_LSB/8]) len <= bw_pkg::clamp_len(wdata[LEN_LSB +: LEN_W], LIM);
      end
   end

   // R3
   len_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n) len <= LIM);
endmodule

// File: rtl/bw_index.sv
module bw_index #(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [LEN_W-1:0] len,
   output logic [LEN_W-1:0] idx
);
   logic last;
   assign last = (idx >= len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (clr)   idx <= '0;
      else if (step)  idx <= last ? '0 : idx + LEN_W'(1);
   end

   // R5
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && idx == len) |=> idx == '0);
   // R10
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(idx));
endmodule

// File: rtl/burst_window.sv
module burst_window #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int WIN_W    = 16,
   parameter int START_W  = 5,
   parameter int LEN_W    = 5,
   parameter int MAX_LEN  = 17,
   parameter int CTRL_OFS = 'h48,
   parameter int WIN_OFS  = 'h4C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [3:0]        bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic [3:0]        reg_be,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata
);
   localparam int LEN_LSB = 8;
   localparam int WORD_W  = START_W + 1;
   localparam int BE_W    = DATA_W / 8;
   localparam int WIN_BE  = WIN_W / 8;

   if (DATA_W != 32) begin : g_bad_data
      $error("burst_window: DATA_W must be 32");
   end
   if (WIN_W > DATA_W || WIN_W % 8 != 0) begin : g_bad_win
      $error("burst_window: WIN_W must be a byte multiple no wider than DATA_W");
   end
   if (MAX_LEN >= (1 << LEN_W) || START_W > 8 || LEN_W > 5) begin : g_bad_len
      $error("burst_window: field widths out of range");
   end
   if (((1 << START_W) + MAX_LEN) * 4 > (1 << ADDR_W)) begin : g_bad_addr
      $error("burst_window: ADDR_W too narrow for the burst range");
   end

   logic               hit_ctrl, hit_win, acc;
   logic [START_W-1:0] start;
   logic [LEN_W-1:0]   len;
   logic [LEN_W-1:0]   idx;
   logic [WORD_W-1:0]  word;
   logic [DATA_W-1:0]  ctrl_q;
   logic [DATA_W-1:0]  win_rd, win_wd;

   assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
   assign hit_win  = (bus_addr == ADDR_W'(WIN_OFS));
   assign acc      = bus_wr | bus_rd;

   bw_ctrl #(.START_W(START_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN),
             .DATA_W(DATA_W), .LEN_LSB(LEN_LSB)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr & hit_ctrl), .be(bus_be),
      .wdata(bus_wdata), .start(start), .len(len));

   bw_index #(.LEN_W(LEN_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .clr(bus_wr & hit_ctrl),
      .step(acc & hit_win), .len(len), .idx(idx));

   assign word = WORD_W'(start) + WORD_W'(idx);

   always_comb begin
      ctrl_q = '0;
      ctrl_q[START_W-1:0] = start;
      ctrl_q[LEN_LSB +: LEN_W] = len;
   end

   if (WIN_W < DATA_W) begin : g_narrow
      assign win_rd = {{(DATA_W-WIN_W){1'b0}}, reg_rdata[WIN_W-1:0]};
      assign win_wd = {{(DATA_W-WIN_W){1'b0}}, bus_wdata[WIN_W-1:0]};
   end else begin : g_full
      assign win_rd = reg_rdata;
      assign win_wd = bus_wdata;
   end

   always_comb begin
      reg_addr  = bus_addr;
      reg_wr    = bus_wr;
      reg_rd    = bus_rd;
      reg_be    = bus_be;
      reg_wdata = bus_wdata;
      bus_rdata = reg_rdata;
      if (hit_ctrl) begin
         reg_wr    = 1'b0;
         reg_rd    = 1'b0;
         bus_rdata = ctrl_q;
      end else if (hit_win) begin
         reg_addr  = ADDR_W'({word, 2'b00});
         reg_be    = bus_be & BE_W'((1 << WIN_BE) - 1);
         reg_wdata = win_wd;
         bus_rdata = win_rd;
      end
   end

   // R6
   ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_ctrl) |=> idx == '0);
   // R7
   pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_ctrl && !hit_win) |=> $stable(idx));
   // R9
   ctrl_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl |-> (!reg_wr && !reg_rd));
   // R4
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) idx <= len);
endmodule

// File: tb/burst_window_test.sv
`timescale 1ns/1ps
module burst_window_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  reg_addr;
   logic        reg_wr, reg_rd;
   logic [3:0]  reg_be;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;

   int n_chk = 0, n_fail = 0;
   int m_start = 0, m_len = 0, m_idx = 0;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] tmem(input logic [7:0] a);
      return {8'h5A, a, ~a, a ^ 8'h3C};
   endfunction
   assign reg_rdata = tmem(reg_addr);

   burst_window uut (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic [7:0] a, input bit wr, input bit rd,
                         input logic [3:0] be, input logic [31:0] wd);
      logic [7:0] ea;
      @(negedge clk);
      bus_addr = a; bus_wr = wr; bus_rd = rd; bus_be = be; bus_wdata = wd;
      #1;
      if (a == 8'h48) begin
         chk(!reg_wr && !reg_rd, "R9", {30'b0, reg_wr, reg_rd}, 32'h0);
         if (rd) chk(bus_rdata == 32'((m_len << 8) | m_start), "R2",
                     bus_rdata, 32'((m_len << 8) | m_start));
      end else if (a == 8'h4C) begin
         ea = 8'((m_start + m_idx) * 4);
         if (wr || rd) begin
            chk(reg_addr == ea, "R4", {24'b0, reg_addr}, {24'b0, ea});
            chk(reg_wr == wr && reg_rd == rd, "R4", {30'b0, reg_wr, reg_rd}, {30'b0, wr, rd});
         end
         if (wr) chk(reg_wdata == {16'b0, wd[15:0]} && reg_be == (be & 4'h3), "R8",
                     reg_wdata, {16'b0, wd[15:0]});
         if (rd) chk(bus_rdata == {16'b0, tmem(ea)[15:0]}, "R8", bus_rdata, {16'b0, tmem(ea)[15:0]});
      end else if (wr || rd) begin
         chk(reg_addr == a && reg_wr == wr && reg_rd == rd && reg_be == be && reg_wdata == wd,
             "R7", {24'b0, reg_addr}, {24'b0, a});
         if (rd) chk(bus_rdata == tmem(a), "R7", bus_rdata, tmem(a));
      end
      @(posedge clk);
      if (a == 8'h48 && wr) begin
         if (be[0]) m_start = int'(wd[4:0]);
         if (be[1]) m_len = (int'(wd[12:8]) > 17) ? 17 : int'(wd[12:8]);
         m_idx = 0;
      end else if (a == 8'h4C && (wr || rd)) begin
         m_idx = (m_idx >= m_len) ? 0 : m_idx + 1;
      end
   endtask

   task automatic ctrl_wr(input int st, input int ln);
      access(8'h48, 1, 0, 4'hF, 32'((ln << 8) | st));
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      access(8'h48, 0, 1, 4'hF, 0);
      chk(bus_rdata == 0, "R1", bus_rdata, 0);
      access(8'h4C, 0, 1, 4'hF, 0);
      // R2: fields and reserved bits
      ctrl_wr(3, 4);
      access(8'h48, 1, 0, 4'hF, 32'hFFFF_E3E5);
      access(8'h48, 0, 1, 4'hF, 0);
      chk(bus_rdata == 32'h0000_0305, "R2", bus_rdata, 32'h0000_0305);
      // R3: clamp at 17
      ctrl_wr(0, 31);
      access(8'h48, 0, 1, 4'hF, 0);
      chk(bus_rdata[12:8] == 5'd17, "R3", {27'b0, bus_rdata[12:8]}, 17);
      // R5: full burst of 18 plus wrap
      ctrl_wr(31, 17);
      for (int i = 0; i < 20; i++) access(8'h4C, i % 2, (i + 1) % 2, 4'hF, 32'(i * 7));
      // length 0: every access hits the start
      ctrl_wr(9, 0);
      for (int i = 0; i < 3; i++) access(8'h4C, 0, 1, 4'h3, 0);
      // R6: mid-burst control write with lane 1 only
      ctrl_wr(2, 5);
      access(8'h4C, 1, 0, 4'hF, 32'hABCD_1234);
      access(8'h4C, 1, 0, 4'h1, 32'h0000_5678);
      access(8'h48, 1, 0, 4'h2, 32'h0000_0300);
      access(8'h4C, 0, 1, 4'hF, 0);
      chk(m_idx == 1, "R6", 32'(m_idx), 1);
      // R7 / R10: pass-through and idle do not move the index
      access(8'h10, 1, 0, 4'hF, 32'hDEAD_BEEF);
      access(8'h4C, 0, 0, 4'h0, 0);
      access(8'h20, 0, 1, 4'hF, 0);
      access(8'h4C, 0, 1, 4'hF, 0);
      // random mix
      for (int i = 0; i < 800; i++) begin
         int k;
         logic [7:0] a;
         k = int'($urandom_range(0, 99));
         if (k < 50) access(8'h4C, k[0], !k[0], 4'($urandom_range(1, 15)), $urandom);
         else if (k < 65) access(8'h48, 1, 0, 4'($urandom_range(0, 15)), $urandom);
         else if (k < 70) access(8'h48, 0, 1, 4'hF, 0);
         else if (k < 90) begin
            a = 8'($urandom_range(0, 255));
            if (a == 8'h48 || a == 8'h4C) a = 8'h50;
            access(a, k[0], !k[0], 4'($urandom_range(0, 15)), $urandom);
         end else access(8'h4C, 0, 0, 4'h0, 0);
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule